// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Underrun Repeat

This block holds outgoing audio samples between a DMA-style producer and a serial audio link that asks for one sample per frame. Sixteen 32-bit words are stored. Whenever fewer than half the entries are occupied, it asks the DMA engine for more. Nothing leaves toward the link until the store has once been filled to half. After that, each frame request from the link takes the oldest word.

If a frame request finds the store empty after transmission has begun, the block sends the previous sample again and sets a sticky underrun flag. That flag can raise an interrupt when enabled. The repeat carries on for as many frames as requested, until new data is written or the link reset is applied.

The frame request arrives as a level strobe from the bit-clock domain. It passes through a two-flop synchronizer and an edge detector, which needs a system clock of at least four times the bit clock. The sample for the link is presented as a held word together with a toggle that flips once per served request. The bit-clock side treats a change of the toggle as "new word is stable".

Top module: `atx_fifo`

## Requirements
- R1: Words leave in the order they were accepted, and up to 16 words can be held at once.
- R2: The write port is valid/ready. `wr_ready` is low exactly while 16 words are held, and a word is stored only in a cycle where both `wr_valid` and `wr_ready` are high.
- R3: A cycle with `wr_valid` high while the store is full drops that word and raises `wr_ovf` for one cycle, on the following clock edge.
- R4: `dma_req` is high whenever fewer than 8 words are held, and low otherwise.
- R5: Until the held count has reached 8 at least once since reset or link reset, frame requests remove nothing and `slot_data` stays 0. `slot_toggle` still flips for each such request.
- R6: A frame request is a rising edge on `frame_req`. `slot_data` and `slot_toggle` change on the third rising `clk` edge after `frame_req` is first seen high at a clock edge, and `slot_data` changes at no other time except link reset.
- R7: A frame request that finds the store empty after transmission has begun leaves `slot_data` at the last sent word and flips `slot_toggle`. This repeats for every such request.
- R8: Such an underrun sets `under_flag`, which stays set until a cycle with `under_clr` high. If an underrun and `under_clr` fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when `under_flag` and `irq_en` are both high.
- R10: A cycle with `link_rst` high empties the store, clears `slot_data`, `slot_toggle` and `under_flag`, and re-arms the half-full start gate of R5. This ends any repeat.
- R11: A word written while `half_mode` is high is stored with bits 31:16 forced to 0. Bits 15:0 are kept.
- R12: After an underrun, a word written later is sent by the next frame request without waiting for the store to refill to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rst | input | 1 | Synchronous link reset, active high |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Store can accept a word |
| wr_data | input | 32 | Offered sample word |
| half_mode | input | 1 | Zero upper 16 bits of written words |
| wr_ovf | output | 1 | One-cycle pulse: a write was attempted while full |
| dma_req | output | 1 | Fewer than 8 words held |
| frame_req | input | 1 | Per-frame sample request, bit-clock domain level |
| slot_data | output | 32 | Sample currently offered to the link |
| slot_toggle | output | 1 | Flips once per served frame request |
| under_clr | input | 1 | Write-one-to-clear strobe for the underrun flag |
| irq_en | input | 1 | Interrupt enable for underrun |
| under_flag | output | 1 | Sticky underrun status |
| irq | output | 1 | Underrun interrupt |

## Verification
The bench aims at frame requests that arrive before the store first reaches half. A design that ignored the start gate would send the first words early instead of zeros. It also drives the store to exactly full, so a wrong level would show up as an early or late `dma_req` or a missing overflow pulse. It then drains the store past empty, where a design that output zero or stale garbage would disagree with the repeated last word. It also checks that a lone word written after the underrun goes out at once, which catches a design that wrongly re-applies the half-full gate. Finally, link reset and the upper-half masking are checked at the ports, together with the three-edge latency of the synchronized request.

// File: rtl/atx_pkg.sv
package atx_pkg;
  parameter int ATX_WORD_W = 32;
  parameter int ATX_DEPTH  = 16;

  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_GATED  = 2'd1,
    ACT_SEND   = 2'd2,
    ACT_REPEAT = 2'd3
  } slot_act_e;
endpackage

// File: rtl/atx_req_sync.sv
module atx_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic req_pulse
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign req_pulse = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/atx_store.sv
module atx_store #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/atx_slot_ctl.sv
module atx_slot_ctl
  import atx_pkg::*;
#(
  parameter int W         = 32,
  parameter int DEPTH     = 16,
  parameter int START_LVL = DEPTH / 2,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req_pulse,
  input  logic [CW-1:0] count,
  input  logic          empty,
  input  logic [W-1:0]  head,
  input  logic          under_clr,
  output logic          pop,
  output logic [W-1:0]  slot_data,
  output logic          slot_toggle,
  output logic          under_flag
);
  logic      started_q;
  slot_act_e act;

  always_comb begin
    act = ACT_IDLE;
    if (req_pulse && !flush) begin
      if (!started_q)  act = ACT_GATED;
      else if (!empty) act = ACT_SEND;
      else             act = ACT_REPEAT;
    end
  end

  assign pop = (act == ACT_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q   <= 1'b0;
      slot_data   <= '0;
      slot_toggle <= 1'b0;
      under_flag  <= 1'b0;
    end else if (flush) begin
      started_q   <= 1'b0;
      slot_data   <= '0;
      slot_toggle <= 1'b0;
      under_flag  <= 1'b0;
    end else begin
      if (count >= CW'(START_LVL)) started_q <= 1'b1;
      if (act != ACT_IDLE) slot_toggle <= ~slot_toggle;
      if (act == ACT_SEND) slot_data <= head;
      if (act == ACT_REPEAT)  under_flag <= 1'b1;
      else if (under_clr)     under_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/atx_fifo.sv
module atx_fifo
  import atx_pkg::*;
#(
  parameter int W         = ATX_WORD_W,
  parameter int DEPTH     = ATX_DEPTH,
  parameter int SYNC_STG  = 2,
  localparam int HALF     = DEPTH / 2,
  localparam int CW       = $clog2(DEPTH) + 1,
  localparam int LO_W     = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         link_rst,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         half_mode,
  output logic         wr_ovf,
  output logic         dma_req,
  input  logic         frame_req,
  output logic [W-1:0] slot_data,
  output logic         slot_toggle,
  input  logic         under_clr,
  input  logic         irq_en,
  output logic         under_flag,
  output logic         irq
);
  logic          req_pulse;
  logic          pop;
  logic [W-1:0]  head;
  logic [CW-1:0] count;
  logic          full;
  logic          empty;
  logic [W-1:0]  store_word;

  atx_req_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (frame_req),
    .req_pulse (req_pulse)
  );

  always_comb begin
    store_word = wr_data;
    if (half_mode) store_word[W-1:LO_W] = '0;
  end

  atx_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (link_rst),
    .push      (wr_valid),
    .push_data (store_word),
    .pop       (pop),
    .head      (head),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  atx_slot_ctl #(.W(W), .DEPTH(DEPTH), .START_LVL(HALF)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (link_rst),
    .req_pulse   (req_pulse),
    .count       (count),
    .empty       (empty),
    .head        (head),
    .under_clr   (under_clr),
    .pop         (pop),
    .slot_data   (slot_data),
    .slot_toggle (slot_toggle),
    .under_flag  (under_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ovf <= 1'b0;
    else        wr_ovf <= wr_valid & full & ~link_rst;
  end

  assign wr_ready = ~full;
  assign dma_req  = (count < CW'(HALF));
  assign irq      = under_flag & irq_en;
endmodule

// File: rtl/atx_fifo_sva.sv
module atx_fifo_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         link_rst,
  input logic         wr_valid,
  input logic         wr_ready,
  input logic         wr_ovf,
  input logic         dma_req,
  input logic         req_pulse,
  input logic [W-1:0] slot_data,
  input logic         under_clr,
  input logic         under_flag,
  input logic         irq_en,
  input logic         irq
);
  AST_OVF_AFTER_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !link_rst) |=> wr_ovf) else $error("ovf"); // R3

  AST_FULL_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !dma_req) else $error("dma"); // R4

  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_pulse && !link_rst) |=> $stable(slot_data)) else $error("slot"); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (under_flag && !under_clr && !link_rst) |=> under_flag) else $error("sticky"); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq) else $error("irq"); // R9

  AST_LINK_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |=> (!under_flag && slot_data == '0 && dma_req)) else $error("lrst"); // R10
endmodule

bind atx_fifo atx_fifo_sva #(.W(W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .link_rst   (link_rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_ovf     (wr_ovf),
  .dma_req    (dma_req),
  .req_pulse  (req_pulse),
  .slot_data  (slot_data),
  .under_clr  (under_clr),
  .under_flag (under_flag),
  .irq_en     (irq_en),
  .irq        (irq)
);

// File: tb/atx_fifo_test.sv
`timescale 1ns/1ps
module atx_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n, link_rst, wr_valid, half_mode, frame_req, under_clr, irq_en;
  logic [31:0] wr_data;
  logic        wr_ready, wr_ovf, dma_req, slot_toggle, under_flag, irq;
  logic [31:0] slot_data;

  always #10 clk = ~clk;

  atx_fifo uut (
    .clk(clk), .rst_n(rst_n), .link_rst(link_rst), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .half_mode(half_mode), .wr_ovf(wr_ovf),
    .dma_req(dma_req), .frame_req(frame_req), .slot_data(slot_data),
    .slot_toggle(slot_toggle), .under_clr(under_clr), .irq_en(irq_en),
    .under_flag(under_flag), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural reference model
  logic [31:0] mq[$];
  logic        m_started, m_toggle, m_under, m_ovf;
  logic [31:0] m_last;
  logic        m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_started = 0; m_toggle = 0; m_under = 0; m_ovf = 0; m_last = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      automatic bit pulse = m_s2 && !m_s3;
      automatic int pre   = mq.size();
      if (link_rst) begin
        mq.delete();
        m_started = 0; m_toggle = 0; m_under = 0; m_ovf = 0; m_last = 0;
      end else begin
        m_ovf = wr_valid && (pre == 16);
        if (under_clr) m_under = 0;
        if (pulse) begin
          m_toggle = !m_toggle;
          if (m_started && pre > 0) m_last = mq.pop_front();
          else if (m_started) m_under = 1;
        end
        if (wr_valid && pre < 16)
          mq.push_back(half_mode ? {16'h0, wr_data[15:0]} : wr_data);
        if (pre >= 8) m_started = 1;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = frame_req;
    end
  end

  task automatic cmp1(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp1("R2 wr_ready", {31'b0, wr_ready}, {31'b0, mq.size() < 16});
    cmp1("R3 wr_ovf", {31'b0, wr_ovf}, {31'b0, m_ovf});
    cmp1("R4 dma_req", {31'b0, dma_req}, {31'b0, mq.size() < 8});
    cmp1("R1 R7 slot_data", slot_data, m_last);
    cmp1("R6 slot_toggle", {31'b0, slot_toggle}, {31'b0, m_toggle});
    cmp1("R8 under_flag", {31'b0, under_flag}, {31'b0, m_under});
    cmp1("R9 irq", {31'b0, irq}, {31'b0, m_under && irq_en});
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic push(logic [31:0] d);
    wr_valid = 1; wr_data = d; tick(); wr_valid = 0;
  endtask

  task automatic frame();
    frame_req = 1; repeat (4) tick();
    frame_req = 0; repeat (4) tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; link_rst = 0; wr_valid = 0; wr_data = 0; half_mode = 0;
    frame_req = 0; under_clr = 0; irq_en = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    cmp1("R4 reset dma_req", {31'b0, dma_req}, 32'd1);
    cmp1("R10 reset slot_data", slot_data, 32'h0);

    // R5: requests before the half-full gate
    for (int i = 0; i < 5; i++) push(32'hA000_0000 | i);
    frame(); frame();
    cmp1("R5 gated slot_data", slot_data, 32'h0);

    // R6: latency of three edges from a level first seen high
    frame_req = 1; tick(); tick();
    cmp1("R6 not yet updated", {31'b0, slot_toggle}, 32'd0);
    tick();
    cmp1("R6 updated on third edge", {31'b0, slot_toggle}, 32'd1);
    frame_req = 0; repeat (4) tick();
    cmp1("R5 still gated", slot_data, 32'h0);

    // fill to full, R2 R3 R4
    for (int i = 5; i < 16; i++) push(32'hA000_0000 | i);
    cmp1("R2 full not ready", {31'b0, wr_ready}, 32'd0);
    cmp1("R4 full no dma", {31'b0, dma_req}, 32'd0);
    wr_valid = 1; wr_data = 32'hFFFF_FFFF; tick(); wr_valid = 0;
    cmp1("R3 overflow pulse", {31'b0, wr_ovf}, 32'd1);

    // R1 ordered draining
    for (int i = 0; i < 3; i++) frame();
    cmp1("R1 third word", slot_data, 32'hA000_0002);
    for (int i = 3; i < 16; i++) frame();
    cmp1("R1 last word", slot_data, 32'hA000_000F);
    cmp1("R4 empty dma", {31'b0, dma_req}, 32'd1);

    // R7 R8 R9 underrun
    frame(); frame();
    cmp1("R7 repeat", slot_data, 32'hA000_000F);
    cmp1("R8 flag set", {31'b0, under_flag}, 32'd1);
    cmp1("R9 irq masked", {31'b0, irq}, 32'd0);
    irq_en = 1; tick();
    cmp1("R9 irq raised", {31'b0, irq}, 32'd1);
    under_clr = 1; tick(); under_clr = 0;
    cmp1("R8 flag cleared", {31'b0, under_flag}, 32'd0);

    // R12 resume without refill
    push(32'h1234_5678);
    frame();
    cmp1("R12 resumed", slot_data, 32'h1234_5678);

    // R11 half mode
    half_mode = 1; push(32'hDEAD_BEEF); half_mode = 0;
    frame();
    cmp1("R11 masked upper", slot_data, 32'h0000_BEEF);

    // R8 set wins over clear in the same cycle
    frame_req = 1; tick(); tick();
    under_clr = 1; tick(); under_clr = 0;
    frame_req = 0; repeat (3) tick();
    cmp1("R8 set wins", {31'b0, under_flag}, 32'd1);

    // R10 link reset
    push(32'h5555_0001); push(32'h5555_0002);
    link_rst = 1; tick(); link_rst = 0;
    cmp1("R10 slot cleared", slot_data, 32'h0);
    cmp1("R10 flag cleared", {31'b0, under_flag}, 32'd0);
    cmp1("R10 dma_req", {31'b0, dma_req}, 32'd1);
    push(32'h7777_0000);
    frame();
    cmp1("R10 gate re-armed", slot_data, 32'h0);

    repeat (4) tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule